// File: doc/BRIEF.md
# Inbound Write Ordering Gate

This block sits between the receive side of a direct-memory-access packet path and a memory bus master. Each incoming packet is offered on a valid/ready handshake together with its source ID, destination ID, priority and a doorbell flag. The gate decides whether the packet may become a bus command now or has to wait. A waiting packet keeps `pkt_valid` high and the gate holds `pkt_ready` low. Because the handshake takes one packet at a time, packets are admitted in arrival order, and at most one command is issued per cycle.

Ordering comes from a table of in-flight commands, up to `SLOTS` (four) deep. A packet is held back when some busy entry has the same source ID and the same destination ID, and a priority greater than or equal to the packet's own. It is also held back when every slot is busy. Once admitted, a command keeps its slot until the bus side pulses completion for that slot.

A doorbell packet is not a bus command. It marks a drain point. After a doorbell is taken, no further packet is admitted until every outstanding command has completed, and then the gate raises its interrupt for one cycle. A second doorbell that arrives while the first is still draining is taken and bounced with a retry pulse.

Top module: `write_order_gate`

## Requirements
- R1: At most `SLOTS` (4) commands are outstanding. When all slots are busy, a non-doorbell packet is held with `pkt_ready` low even if it conflicts with nothing.
- R2: A non-doorbell packet is held while any busy slot has an equal source ID, an equal destination ID and a priority greater than or equal to the packet's priority. A larger `pkt_pri` value means more urgent.
- R3: A non-doorbell packet that differs from every busy slot in at least one of source ID, destination ID or priority (by having a strictly higher priority) is admitted when a slot is free. In that cycle `pkt_ready` and `cmd_issue` are both high and `cmd_slot` is the lowest-numbered free slot.
- R4: A `cmd_done` pulse frees slot `cmd_done_slot` from the next cycle on. A packet blocked only by that slot is admitted in the cycle after the completion pulse, and not in the same cycle.
- R5: A doorbell is taken (`pkt_ready` high, `cmd_issue` low) when none is pending. `irq` is high for exactly one cycle: the first cycle in which a doorbell is pending and no command is outstanding. The earliest this can be is the cycle after the doorbell is taken.
- R6: A doorbell offered while a previous one is pending is taken with `retry` high in the same cycle. It does not issue a command and does not extend or restart the pending drain.
- R7: While a doorbell is pending, including its `irq` cycle, non-doorbell packets are held. The first one is admitted the cycle after `irq`.
- R8: After reset no slot is busy and no doorbell is pending, so `irq`, `retry` and `cmd_issue` are low and the first packet is issued to slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pkt_valid | input | 1 | A packet is offered |
| pkt_ready | output | 1 | The offered packet is taken this cycle |
| pkt_src | input | SRC_W | Source ID of the offered packet |
| pkt_dst | input | DST_W | Destination ID of the offered packet |
| pkt_pri | input | PRI_W | Priority, larger is more urgent |
| pkt_doorbell | input | 1 | The offered packet is a doorbell |
| cmd_issue | output | 1 | Issue a bus command for the taken packet |
| cmd_slot | output | SLOT_W | Slot assigned to the issued command |
| cmd_done | input | 1 | Completion pulse of an outstanding command |
| cmd_done_slot | input | SLOT_W | Slot of the completing command |
| retry | output | 1 | The taken doorbell is bounced |
| irq | output | 1 | One-cycle interrupt after a doorbell drain |

## Verification
On every cycle, the assertions check four things against a command count rebuilt from the issue and completion ports. No command is issued into a full table. Issues and retries happen only on an accepted packet of the right kind. The interrupt never rises while a command is still outstanding. The interrupt lasts a single cycle. The three-way compare, the lowest-free-slot choice, the one-cycle delay after completion, and the blocking of new packets during a drain all depend on particular IDs and timing, so only the bench's directed scenarios show them.

// File: rtl/wog_pkg.sv
package wog_pkg;
    localparam int unsigned WOG_SLOTS = 4;
    localparam int unsigned WOG_SRC_W = 8;
    localparam int unsigned WOG_DST_W = 8;
    localparam int unsigned WOG_PRI_W = 2;
endpackage

// File: rtl/wog_match.sv
module wog_match #(
    parameter int unsigned SLOTS = 4,
    parameter int unsigned SRC_W = 8,
    parameter int unsigned DST_W = 8,
    parameter int unsigned PRI_W = 2
) (
    input  logic [SLOTS-1:0]       busy,
    input  logic [SLOTS*SRC_W-1:0] tab_src,
    input  logic [SLOTS*DST_W-1:0] tab_dst,
    input  logic [SLOTS*PRI_W-1:0] tab_pri,
    input  logic [SRC_W-1:0]       req_src,
    input  logic [DST_W-1:0]       req_dst,
    input  logic [PRI_W-1:0]       req_pri,
    output logic                   hit
);
    logic [SLOTS-1:0] hit_vec;

    for (genvar g = 0; g < SLOTS; g++) begin : g_cmp
        assign hit_vec[g] = busy[g]
                         && (tab_src[g*SRC_W +: SRC_W] == req_src)
                         && (tab_dst[g*DST_W +: DST_W] == req_dst)
                         && (req_pri <= tab_pri[g*PRI_W +: PRI_W]);
    end

    assign hit = |hit_vec;
endmodule

// File: rtl/wog_pick.sv
module wog_pick #(
    parameter int unsigned SLOTS  = 4,
    localparam int unsigned SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input  logic [SLOTS-1:0]  busy,
    output logic              any_free,
    output logic [SLOT_W-1:0] idx
);
    always_comb begin
        idx = '0;
        for (int i = SLOTS - 1; i >= 0; i--) begin
            if (!busy[i]) idx = SLOT_W'(i);
        end
        any_free = ~&busy;
    end
endmodule

// File: rtl/write_order_gate.sv
module write_order_gate
    import wog_pkg::*;
#(
    parameter int unsigned SLOTS  = WOG_SLOTS,
    parameter int unsigned SRC_W  = WOG_SRC_W,
    parameter int unsigned DST_W  = WOG_DST_W,
    parameter int unsigned PRI_W  = WOG_PRI_W,
    localparam int unsigned SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pkt_valid,
    output logic              pkt_ready,
    input  logic [SRC_W-1:0]  pkt_src,
    input  logic [DST_W-1:0]  pkt_dst,
    input  logic [PRI_W-1:0]  pkt_pri,
    input  logic              pkt_doorbell,
    output logic              cmd_issue,
    output logic [SLOT_W-1:0] cmd_slot,
    input  logic              cmd_done,
    input  logic [SLOT_W-1:0] cmd_done_slot,
    output logic              retry,
    output logic              irq
);
    typedef struct packed {
        logic [SLOTS-1:0]       busy;
        logic [SLOTS*SRC_W-1:0] src;
        logic [SLOTS*DST_W-1:0] dst;
        logic [SLOTS*PRI_W-1:0] pri;
        logic                   db_pend;
    } state_t;

    state_t st_d, st_q;

    logic              hit;
    logic              any_free;
    logic [SLOT_W-1:0] free_idx;

    wog_match #(
        .SLOTS (SLOTS),
        .SRC_W (SRC_W),
        .DST_W (DST_W),
        .PRI_W (PRI_W)
    ) u_match (
        .busy    (st_q.busy),
        .tab_src (st_q.src),
        .tab_dst (st_q.dst),
        .tab_pri (st_q.pri),
        .req_src (pkt_src),
        .req_dst (pkt_dst),
        .req_pri (pkt_pri),
        .hit     (hit)
    );

    wog_pick #(
        .SLOTS (SLOTS)
    ) u_pick (
        .busy     (st_q.busy),
        .any_free (any_free),
        .idx      (free_idx)
    );

    always_comb begin
        st_d      = st_q;
        pkt_ready = 1'b0;
        cmd_issue = 1'b0;
        retry     = 1'b0;
        cmd_slot  = free_idx;
        // drain finished: signal once and close the pending doorbell
        irq       = st_q.db_pend && (st_q.busy == '0);
        if (irq) st_d.db_pend = 1'b0;

        if (pkt_valid) begin
            if (pkt_doorbell) begin
                pkt_ready = 1'b1;
                if (st_q.db_pend) retry = 1'b1;
                else              st_d.db_pend = 1'b1;
            end else if (!st_q.db_pend && any_free && !hit) begin
                pkt_ready = 1'b1;
                cmd_issue = 1'b1;
                st_d.busy[free_idx] = 1'b1;
                st_d.src[free_idx*SRC_W +: SRC_W] = pkt_src;
                st_d.dst[free_idx*DST_W +: DST_W] = pkt_dst;
                st_d.pri[free_idx*PRI_W +: PRI_W] = pkt_pri;
            end
        end

        if (cmd_done) st_d.busy[cmd_done_slot] = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/wog_checker.sv
module wog_checker #(
    parameter int unsigned SLOTS  = 4,
    localparam int unsigned SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input logic clk,
    input logic rst_n,
    input logic pkt_valid,
    input logic pkt_ready,
    input logic pkt_doorbell,
    input logic cmd_issue,
    input logic cmd_done,
    input logic retry,
    input logic irq
);
    logic [SLOT_W:0] live_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) live_cnt <= '0;
        else live_cnt <= live_cnt + (SLOT_W+1)'(cmd_issue) - (SLOT_W+1)'(cmd_done);
    end

    p_no_overflow_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_issue |-> (live_cnt < (SLOT_W+1)'(SLOTS)));

    p_issue_on_accept_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_issue |-> (pkt_valid && pkt_ready && !pkt_doorbell));

    p_retry_on_doorbell_r6: assert property (@(posedge clk) disable iff (!rst_n)
        retry |-> (pkt_valid && pkt_ready && pkt_doorbell && !cmd_issue));

    p_irq_after_drain_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (live_cnt == '0));

    p_irq_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);
endmodule

bind write_order_gate wog_checker #(
    .SLOTS (SLOTS)
) u_wog_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .pkt_valid    (pkt_valid),
    .pkt_ready    (pkt_ready),
    .pkt_doorbell (pkt_doorbell),
    .cmd_issue    (cmd_issue),
    .cmd_done     (cmd_done),
    .retry        (retry),
    .irq          (irq)
);

// File: tb/write_order_gate_bench.sv
module write_order_gate_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pkt_valid = 1'b0;
    logic       pkt_ready;
    logic [7:0] pkt_src = '0;
    logic [7:0] pkt_dst = '0;
    logic [1:0] pkt_pri = '0;
    logic       pkt_doorbell = 1'b0;
    logic       cmd_issue;
    logic [1:0] cmd_slot;
    logic       cmd_done = 1'b0;
    logic [1:0] cmd_done_slot = '0;
    logic       retry;
    logic       irq;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    write_order_gate u_write_order_gate (
        .clk (clk), .rst_n (rst_n),
        .pkt_valid (pkt_valid), .pkt_ready (pkt_ready),
        .pkt_src (pkt_src), .pkt_dst (pkt_dst), .pkt_pri (pkt_pri),
        .pkt_doorbell (pkt_doorbell),
        .cmd_issue (cmd_issue), .cmd_slot (cmd_slot),
        .cmd_done (cmd_done), .cmd_done_slot (cmd_done_slot),
        .retry (retry), .irq (irq)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // drive one cycle at the falling edge, settle, leave outputs ready to sample
    task automatic step(input bit v, input int s, input int d, input int p, input bit db,
                        input bit dn, input int ds);
        @(negedge clk);
        pkt_valid = v; pkt_src = 8'(s); pkt_dst = 8'(d); pkt_pri = 2'(p);
        pkt_doorbell = db; cmd_done = dn; cmd_done_slot = 2'(ds);
        #5;
    endtask

    task automatic idle();
        step(0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic expect_issue(input string req, input int slot);
        check(req, "pkt_ready", int'(pkt_ready), 1);
        check(req, "cmd_issue", int'(cmd_issue), 1);
        check(req, "cmd_slot", int'(cmd_slot), slot);
    endtask

    task automatic expect_hold(input string req);
        check(req, "pkt_ready", int'(pkt_ready), 0);
        check(req, "cmd_issue", int'(cmd_issue), 0);
    endtask

    task automatic t_reset();
        idle();
        check("R8", "irq", int'(irq), 0);
        check("R8", "retry", int'(retry), 0);
        check("R8", "cmd_issue", int'(cmd_issue), 0);
    endtask

    task automatic t_admit();
        step(1, 1, 2, 1, 0, 0, 0); expect_issue("R8", 0);
        step(1, 1, 2, 2, 0, 0, 0); expect_issue("R3", 1);  // higher priority passes
        step(1, 1, 3, 0, 0, 0, 0); expect_issue("R3", 2);  // other destination passes
    endtask

    task automatic t_conflict();
        step(1, 1, 2, 1, 0, 0, 0); expect_hold("R2");      // equal priority
        step(1, 1, 2, 0, 0, 0, 0); expect_hold("R2");      // lower priority
        step(1, 1, 2, 1, 0, 1, 1); expect_hold("R4");      // slot1 completes
        step(1, 1, 2, 1, 0, 0, 0); expect_hold("R2");      // slot0 still conflicts
        step(1, 1, 2, 1, 0, 1, 0); expect_hold("R4");      // same cycle as completion
        step(1, 1, 2, 1, 0, 0, 0); expect_issue("R4", 0);  // next cycle
    endtask

    task automatic t_full();
        step(1, 5, 5, 0, 0, 0, 0); expect_issue("R3", 1);
        step(1, 6, 6, 0, 0, 0, 0); expect_issue("R1", 3);
        step(1, 7, 7, 3, 0, 0, 0); expect_hold("R1");
        step(1, 7, 7, 3, 0, 1, 3); expect_hold("R1");
        step(1, 7, 7, 3, 0, 0, 0); expect_issue("R1", 3);
        for (int k = 0; k < 4; k++) step(0, 0, 0, 0, 0, 1, k);
        step(1, 1, 2, 1, 0, 0, 0); expect_issue("R4", 0); // old entries gone
        step(0, 0, 0, 0, 0, 1, 0);
        idle();
    endtask

    task automatic t_doorbell();
        step(1, 9, 9, 0, 0, 0, 0); expect_issue("R3", 0);
        step(1, 0, 0, 0, 1, 0, 0);
        check("R5", "pkt_ready", int'(pkt_ready), 1);
        check("R5", "cmd_issue", int'(cmd_issue), 0);
        check("R5", "retry", int'(retry), 0);
        step(1, 0, 0, 0, 1, 0, 0);
        check("R6", "pkt_ready", int'(pkt_ready), 1);
        check("R6", "retry", int'(retry), 1);
        check("R5", "irq while busy", int'(irq), 0);
        step(1, 10, 10, 0, 0, 0, 0); expect_hold("R7");
        step(1, 10, 10, 0, 0, 1, 0); expect_hold("R7");
        check("R5", "irq on done cycle", int'(irq), 0);
        step(1, 10, 10, 0, 0, 0, 0);
        check("R5", "irq after drain", int'(irq), 1);
        expect_hold("R7");
        step(1, 10, 10, 0, 0, 0, 0);
        check("R5", "irq pulse end", int'(irq), 0);
        check("R6", "retry quiet", int'(retry), 0);
        expect_issue("R7", 0);
        step(0, 0, 0, 0, 0, 1, 0);
        idle();
        // doorbell on an empty table: irq the very next cycle
        step(1, 0, 0, 0, 1, 0, 0);
        check("R5", "pkt_ready empty", int'(pkt_ready), 1);
        step(1, 0, 0, 0, 1, 0, 0);
        check("R5", "irq empty", int'(irq), 1);
        check("R6", "retry in irq cycle", int'(retry), 1);
        idle();
        check("R6", "no restarted drain", int'(irq), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_reset();
        t_admit();
        t_conflict();
        t_full();
        t_doorbell();
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end
endmodule